// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Bus Handshake

This block sits between four peripheral request lines and a host processor's bus. It qualifies each incoming request against a global enable, a per-channel enable and a per-channel mask. Any qualified request raises a single hold request toward the host. Once the host answers with a hold acknowledge, the block raises the acknowledge of exactly one channel, chosen by fixed priority.

The acknowledge stays locked to that channel until service ends. Service ends in one of two ways: the count logic reports that its final transfer has happened, or an end-of-process indication is forced in from outside. When the block itself completes a transfer, it drives an end-of-process pulse out. The active level of every request input and every acknowledge output can be chosen per line.

Address and count generation, strobe timing and register access are outside this block. The mask register, polarity selections and enables appear as plain configuration inputs.

Top module: `dmarb_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every mask bit to 1 (masked), clears `hold_req` and `eop_out`, and drives every `ack_pin[i]` to its inactive level, which equals `ack_low[i]`.
- R2: A channel is ignored, and cannot raise `hold_req`, while its mask bit is 1, while its `ch_en[i]` is 0, or while `glb_en` is 0.
- R3: When `hold_req` is low, a qualified request sampled at a rising edge raises `hold_req` after that edge.
- R4: No acknowledge is active unless `hold_req` is high. An acknowledge becomes active only after an edge at which the block was waiting for the grant and sampled `hold_ack` high.
- R5: At the grant edge, the acknowledged channel is the lowest-numbered qualified channel (channel 0 highest). At most one acknowledge is active at any time.
- R6: Request `i` is active when `dreq_pin[i]` differs from `req_low[i]`: with `req_low[i]`=1 a low pin requests, and with 0 a high pin requests.
- R7: An active acknowledge drives `ack_pin[i]` = NOT `ack_low[i]`, and an inactive one drives `ack_pin[i]` = `ack_low[i]`.
- R8: While a channel is serviced, its acknowledge stays on that same channel until service ends. New requests, including ones of higher priority, do not move it.
- R9: `eop_ext` sampled high during service ends service: the acknowledge is inactive after that edge. If `tc_hit` is low at the same edge, `eop_out` stays low.
- R10: `tc_hit` sampled high during service ends service and makes `eop_out` high for exactly the one following cycle. `tc_hit` outside service has no effect.
- R11: At the edge that ends service, `hold_req` drops if no qualified request is present. Otherwise it stays high and a new grant follows the usual handshake.
- R12: `mask_load` high at an edge loads `mask_value` into the mask register (bit i = 1 masks channel i). The new mask governs qualification from the next edge on.
- R13: If every qualified request goes away while the block waits for `hold_ack`, `hold_req` drops after that edge and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| glb_en | input | 1 | Global controller enable |
| ch_en | input | NCH | Per-channel enable |
| mask_load | input | 1 | Load strobe for the mask register |
| mask_value | input | NCH | New mask, bit i = 1 masks channel i |
| req_low | input | NCH | 1: request i is active-low |
| ack_low | input | NCH | 1: acknowledge i is active-low |
| dreq_pin | input | NCH | Raw request lines |
| hold_ack | input | 1 | Bus grant from the host |
| eop_ext | input | 1 | External end-of-process, active high |
| tc_hit | input | 1 | Final transfer done, from count logic |
| hold_req | output | 1 | Bus request to the host |
| ack_pin | output | NCH | Acknowledge lines, polarity per `ack_low` |
| eop_out | output | 1 | End-of-process pulse on internal completion |

## Verification
The assertions take the acknowledge polarity selection as static while any acknowledge is active. They also take the host as keeping its grant for the length of a service. The stimulus therefore changes `ack_low` only when no channel is in service. In the random phase it never touches `ack_low`, and it releases `hold_ack` only when the reference model shows no service in progress. Request, mask, enable and end-of-process inputs stay free, so preemption attempts, withdrawals and simultaneous end conditions all occur.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WAIT  = 2'd1,
        ARB_SERVE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dmarb_req_qual.sv
module dmarb_req_qual #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] dreq_pin,
    input  logic [NCH-1:0] req_low,
    input  logic [NCH-1:0] mask_q,
    input  logic [NCH-1:0] ch_en,
    input  logic           glb_en,
    output logic [NCH-1:0] qual
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic active;
        assign active  = dreq_pin[i] ^ req_low[i];
        assign qual[i] = active & ~mask_q[i] & ch_en[i] & glb_en;
    end
endmodule

// File: rtl/dmarb_prio_pick.sv
module dmarb_prio_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] qual,
    output logic [NCH-1:0] pick,
    output logic           any
);
    logic [NCH:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NCH; i++) begin : g_pick
        assign pick[i]   = qual[i] & ~seen[i];
        assign seen[i+1] = seen[i] | qual[i];
    end
    assign any = seen[NCH];
endmodule

// File: rtl/dmarb_ack_drive.sv
module dmarb_ack_drive #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] grant_q,
    input  logic [NCH-1:0] ack_low,
    output logic [NCH-1:0] ack_pin
);
    for (genvar i = 0; i < NCH; i++) begin : g_drv
        assign ack_pin[i] = grant_q[i] ^ ack_low[i];
    end
endmodule

// File: rtl/dmarb_top.sv
module dmarb_top #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           glb_en,
    input  logic [NCH-1:0] ch_en,
    input  logic           mask_load,
    input  logic [NCH-1:0] mask_value,
    input  logic [NCH-1:0] req_low,
    input  logic [NCH-1:0] ack_low,
    input  logic [NCH-1:0] dreq_pin,
    input  logic           hold_ack,
    input  logic           eop_ext,
    input  logic           tc_hit,
    output logic           hold_req,
    output logic [NCH-1:0] ack_pin,
    output logic           eop_out
);
    import dmarb_pkg::*;

    localparam logic [NCH-1:0] ALL_MASKED = {NCH{1'b1}};
    localparam logic [NCH-1:0] NO_GRANT   = '0;

    typedef struct packed {
        arb_state_e     fsm;
        logic [NCH-1:0] grant;
        logic [NCH-1:0] mask;
        logic           hold;
        logic           eop;
    } arb_regs_t;

    arb_regs_t r_q, r_d;

    logic [NCH-1:0] qual;
    logic [NCH-1:0] pick;
    logic           any_qual;
    logic           svc_end;

    dmarb_req_qual #(.NCH(NCH)) u_qual (
        .dreq_pin (dreq_pin),
        .req_low  (req_low),
        .mask_q   (r_q.mask),
        .ch_en    (ch_en),
        .glb_en   (glb_en),
        .qual     (qual)
    );

    dmarb_prio_pick #(.NCH(NCH)) u_pick (
        .qual (qual),
        .pick (pick),
        .any  (any_qual)
    );

    dmarb_ack_drive #(.NCH(NCH)) u_drv (
        .grant_q (r_q.grant),
        .ack_low (ack_low),
        .ack_pin (ack_pin)
    );

    assign svc_end = eop_ext | tc_hit;

    always_comb begin
        r_d     = r_q;
        r_d.eop = 1'b0;
        if (mask_load) begin
            r_d.mask = mask_value;
        end
        unique case (r_q.fsm)
            ARB_IDLE: begin
                if (any_qual) begin
                    r_d.fsm  = ARB_WAIT;
                    r_d.hold = 1'b1;
                end
            end
            ARB_WAIT: begin
                if (!any_qual) begin
                    r_d.fsm  = ARB_IDLE;
                    r_d.hold = 1'b0;
                end else if (hold_ack) begin
                    r_d.fsm   = ARB_SERVE;
                    r_d.grant = pick;
                end
            end
            ARB_SERVE: begin
                if (svc_end) begin
                    r_d.grant = NO_GRANT;
                    r_d.eop   = tc_hit;
                    r_d.hold  = any_qual;
                    r_d.fsm   = any_qual ? ARB_WAIT : ARB_IDLE;
                end
            end
            default: begin
                r_d.fsm   = ARB_IDLE;
                r_d.grant = NO_GRANT;
                r_d.hold  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.fsm   <= ARB_IDLE;
            r_q.grant <= NO_GRANT;
            r_q.mask  <= ALL_MASKED;
            r_q.hold  <= 1'b0;
            r_q.eop   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_req = r_q.hold;
    assign eop_out  = r_q.eop;

endmodule

// File: rtl/dmarb_chk.sv
module dmarb_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] ack_low,
    input logic           hold_ack,
    input logic           eop_ext,
    input logic           tc_hit,
    input logic           hold_req,
    input logic [NCH-1:0] ack_pin,
    input logic           eop_out
);
    logic [NCH-1:0] act;
    assign act = ack_pin ^ ack_low;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!hold_req && !eop_out && act == '0));                    // R1

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act));                                                    // R5

    AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act != '0) |-> hold_req);                                          // R4

    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(act != '0) |-> $past(hold_ack));                              // R4

    AST_GRANT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        ((act != '0) && !eop_ext && !tc_hit) |=> $stable(act));              // R8

    AST_END_DROPS_ACK: assert property (@(posedge clk) disable iff (rst)
        ((act != '0) && (eop_ext || tc_hit)) |=> (act == '0));               // R9

    AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eop_out |=> !eop_out);                                              // R10
endmodule

bind dmarb_top dmarb_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_low  (ack_low),
    .hold_ack (hold_ack),
    .eop_ext  (eop_ext),
    .tc_hit   (tc_hit),
    .hold_req (hold_req),
    .ack_pin  (ack_pin),
    .eop_out  (eop_out)
);

// File: tb/dmarb_top_tb.sv
module dmarb_top_tb;
    localparam int NCH = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst, glb_en, mask_load, hold_ack, eop_ext, tc_hit;
    logic [NCH-1:0] ch_en, mask_value, req_low, ack_low, dreq_pin;
    logic hold_req, eop_out;
    logic [NCH-1:0] ack_pin;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmarb_top #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en),
        .mask_load(mask_load), .mask_value(mask_value),
        .req_low(req_low), .ack_low(ack_low), .dreq_pin(dreq_pin),
        .hold_ack(hold_ack), .eop_ext(eop_ext), .tc_hit(tc_hit),
        .hold_req(hold_req), .ack_pin(ack_pin), .eop_out(eop_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R1";

    int m_state;
    int m_ack;
    bit m_hold, m_eop;
    logic [NCH-1:0] m_mask;

    task automatic check(string what, logic [NCH-1:0] got, logic [NCH-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        bit anyv;
        int first;
        logic [NCH-1:0] exp_ack;
        @(posedge clk);
        if (rst) begin
            m_state = 0; m_ack = -1; m_hold = 0; m_eop = 0; m_mask = '1;
        end else begin
            anyv = 0; first = -1;
            for (int i = 0; i < NCH; i++) begin
                if ((dreq_pin[i] != req_low[i]) && !m_mask[i] && ch_en[i] && glb_en) begin
                    anyv = 1;
                    if (first < 0) first = i;
                end
            end
            m_eop = 0;
            if (m_state == 0) begin
                if (anyv) begin m_state = 1; m_hold = 1; end
            end else if (m_state == 1) begin
                if (!anyv) begin m_state = 0; m_hold = 0; end
                else if (hold_ack) begin m_state = 2; m_ack = first; end
            end else begin
                if (eop_ext || tc_hit) begin
                    m_ack = -1; m_eop = tc_hit; m_hold = anyv;
                    m_state = anyv ? 1 : 0;
                end
            end
            if (mask_load) m_mask = mask_value;
        end
        @(negedge clk);
        for (int i = 0; i < NCH; i++) exp_ack[i] = (m_ack == i) ^ ack_low[i];
        check("hold_req", {{(NCH-1){1'b0}}, hold_req}, {{(NCH-1){1'b0}}, m_hold});
        check("ack_pin", ack_pin, exp_ack);
        check("eop_out", {{(NCH-1){1'b0}}, eop_out}, {{(NCH-1){1'b0}}, m_eop});
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; glb_en = 1; ch_en = '1; mask_load = 0; mask_value = '0;
        req_low = '0; ack_low = '0; dreq_pin = '0;
        hold_ack = 0; eop_ext = 0; tc_hit = 0;
        // R1: reset state
        tag = "R1"; ticks(2);
        rst = 0;
        // R2: masked after reset, request ignored
        tag = "R2"; dreq_pin = 4'b0100; ticks(3);
        // R12: unmask all
        tag = "R12"; mask_load = 1; mask_value = '0; tick(); mask_load = 0;
        // R3: hold raised
        tag = "R3"; tick();
        // R13: withdraw before grant
        tag = "R13"; dreq_pin = '0; ticks(2);
        // R4: wait for hold_ack
        tag = "R4"; dreq_pin = 4'b0100; ticks(4);
        hold_ack = 1; ticks(2);
        // R10: end via tc_hit
        tag = "R10"; tc_hit = 1; dreq_pin = '0; tick(); tc_hit = 0; ticks(2);
        // R5: priority among 1 and 3
        tag = "R5"; dreq_pin = 4'b1010; ticks(3);
        // R8: higher priority request does not preempt
        tag = "R8"; dreq_pin = 4'b1011; ticks(3);
        // R11: end with pending request keeps hold, regrants to channel 0
        tag = "R11"; tc_hit = 1; tick(); tc_hit = 0; ticks(3);
        // R9: external end, no pending request
        tag = "R9"; eop_ext = 1; dreq_pin = '0; tick(); eop_ext = 0; ticks(2);
        tag = "R10"; tc_hit = 1; ticks(2); tc_hit = 0;
        // R6: active-low requests
        tag = "R6"; hold_ack = 0; req_low = '1; dreq_pin = '1; ticks(2);
        dreq_pin = 4'b1011; ticks(2); hold_ack = 1; ticks(2);
        eop_ext = 1; dreq_pin = '1; tick(); eop_ext = 0; ticks(1);
        // R7: active-low acknowledges
        tag = "R7"; ack_low = 4'b0101; tick();
        dreq_pin = 4'b1110; ticks(3);
        dreq_pin = 4'b1111; eop_ext = 1; tick(); eop_ext = 0; tick();
        dreq_pin = 4'b1011; ticks(3);
        eop_ext = 1; dreq_pin = '1; tick(); eop_ext = 0; tick();
        req_low = '0; dreq_pin = '0; ack_low = '0; tick();
        // R2: mask, channel enable, global enable
        tag = "R2"; hold_ack = 0;
        mask_load = 1; mask_value = 4'b0010; tick(); mask_load = 0;
        dreq_pin = 4'b0010; ticks(3);
        ch_en = 4'b1011; dreq_pin = 4'b0100; ticks(3);
        ch_en = '1; glb_en = 0; dreq_pin = 4'b1101; ticks(3);
        glb_en = 1; tick(); hold_ack = 1; ticks(2);
        tag = "R12"; mask_load = 1; mask_value = '0; eop_ext = 1; dreq_pin = '0;
        tick(); mask_load = 0; eop_ext = 0; ticks(2);
        // R5: random mixed stimulus, polarity fixed
        tag = "R5";
        for (int k = 0; k < 3000; k++) begin
            dreq_pin = NCH'($urandom);
            ch_en = ($urandom_range(0, 7) == 0) ? NCH'($urandom) : '1;
            glb_en = ($urandom_range(0, 15) != 0);
            mask_load = ($urandom_range(0, 9) == 0);
            mask_value = NCH'($urandom) & NCH'($urandom);
            eop_ext = ($urandom_range(0, 7) == 0);
            tc_hit = ($urandom_range(0, 7) == 0);
            if (m_state != 2) hold_ack = ($urandom_range(0, 2) != 0);
            tick();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule